// File: doc/BRIEF.md
# Event Counter Slice with Agent Filtering

This block is a performance-monitor slice for an on-chip fabric. It owns four 32-bit event counters. Each counter is steered by its own 8-bit event code, which picks one of three things: the clock itself, a shared divide-by-64 tick, or one of the incoming event strobes. Each strobe arrives tagged with the index of the agent that caused it, and a 64-bit mask drops strobes from any agent whose mask bit is set.

Software controls the slice through a simple register port. Writes take effect on the clock edge and reads are combinational from the current state. Counting needs three things at once: the global enable, the counter's own enable bit, and a matching event. Each enable bit and each interrupt-enable bit has a set address and a clear address. A counter that wraps raises its overflow flag. Any overflow flag whose interrupt enable is also set drives the level interrupt output.

Top module: `evc_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Counter n is read and written at address 0x000+4n. A write loads the value on that edge, and counting continues from it. An event in the same cycle as the write is dropped.
- R3: The event-code register of counter n sits at 0x400+4n and keeps only bits 7:0 (the upper bits read 0). Code 0x00 counts every enabled cycle.
- R4: Code 0x01 counts one event per 64 cycles of a shared prescaler. The prescaler advances only while the global enable is 1 and is cleared by the counter-reset action. Its first tick comes on the 64th enabled cycle.
- R5: Code 0x02+k counts strobe `ev_pulse[k]` for k below 8. Every other code counts nothing.
- R6: The mask at 0xA00 covers agents 0..31 and the mask at 0xA04 covers agents 32..63. Bit i of the 64-bit mask belongs to agent i. A strobe counts only when its agent's bit is 0. Codes 0x00 and 0x01 are not filtered.
- R7: Writing 1 to bit n at 0xC00 sets the enable of counter n. Writing 1 to bit n at 0xC20 clears it. Zero bits change nothing, and both addresses read back the enable vector. A disabled counter holds its value.
- R8: The interrupt enables follow the same set/clear rule at 0xC40 (set) and 0xC60 (clear), and both addresses read back the vector.
- R9: At 0xE04, bit 0 is the global enable and reads back. While it is 0, no counter and no prescaler advances.
- R10: Writing 1 to bit 1 of 0xE04 zeroes all counters and the prescaler on that edge and drops that cycle's events. Bit 1 always reads 0.
- R11: When counter n steps from 0xFFFFFFFF to 0, bit n of 0xC80 is set. Writing 1 to that bit clears it, and a new wrap in the same cycle wins over the clear.
- R12: `irq` is high exactly while some overflow bit and its matching interrupt-enable bit are both 1.
- R13: Addresses outside the map read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_pulse | input | 8 | Event strobes, one per source |
| ev_agent | input | 48 | Agent index of each strobe, 6 bits per source |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable and known whenever `bus_we` is high. They also assume that only one register is written per cycle, so a counter load and a counter-reset action never occur in the same cycle. The stimulus drives one write or read per cycle, changes inputs only between clock edges, and keeps the 6-bit agent fields inside the 64-agent range. Strobes and agent indices are randomized, including cycles in which a counter write coincides with a counting event.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ADDR_W = 12;
  localparam int CODE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CNT   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_AMSK0 = 12'hA00;
  localparam logic [ADDR_W-1:0] OFS_AMSK1 = 12'hA04;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'hC00;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'hC20;
  localparam logic [ADDR_W-1:0] OFS_IESET = 12'hC40;
  localparam logic [ADDR_W-1:0] OFS_IECLR = 12'hC60;
  localparam logic [ADDR_W-1:0] OFS_OVF   = 12'hC80;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hE04;

  localparam logic [CODE_W-1:0] CODE_CYCLE  = 8'h00;
  localparam logic [CODE_W-1:0] CODE_DIV64  = 8'h01;
  localparam int                CODE_STROBE = 2;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic ie_set;
    logic ie_clr;
    logic ovf_clr;
    logic ctrl;
    logic amsk0;
    logic amsk1;
  } evc_wsel_t;
endpackage

// File: rtl/evc_prescale.sv
module evc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr)      pre_d = '0;
    else if (run) pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run & (pre_q == LAST);
endmodule

// File: rtl/evc_select.sv
module evc_select #(
  parameter int NUM_EVT = 8,
  parameter int AG_W    = 6
) (
  input  logic [evc_pkg::CODE_W-1:0] code,
  input  logic                       tick,
  input  logic [NUM_EVT-1:0]         ev_pulse,
  input  logic [NUM_EVT*AG_W-1:0]    ev_agent,
  input  logic [(1<<AG_W)-1:0]       agent_mask,
  output logic                       hit
);
  import evc_pkg::*;

  always_comb begin
    hit = 1'b0;
    if (code == CODE_CYCLE) hit = 1'b1;
    else if (code == CODE_DIV64) hit = tick;
    else begin
      for (int k = 0; k < NUM_EVT; k++) begin
        if (code == CODE_W'(CODE_STROBE + k))
          hit = ev_pulse[k] & ~agent_mask[ev_agent[k*AG_W +: AG_W]];
      end
    end
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  assign step = inc & ~wr & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (wr)        cnt_d = wdata;
    else if (clr)  cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = step & (&cnt_q);
endmodule

// File: rtl/evc_unit.sv
module evc_unit #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8,
  parameter int DATA_W  = 32,
  parameter int DIV     = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_we,
  input  logic [evc_pkg::ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_EVT-1:0]             ev_pulse,
  input  logic [NUM_EVT*$clog2(2*DATA_W)-1:0] ev_agent,
  output logic                           irq
);
  import evc_pkg::*;

  localparam int NUM_AG = 2 * DATA_W;
  localparam int AG_W   = $clog2(NUM_AG);

  evc_wsel_t             wsel;
  logic [NUM_CNT-1:0]    cnt_wr, type_wr;
  logic [NUM_CNT-1:0]    en_q, en_d, ie_q, ie_d, ovf_q, ovf_d;
  logic [NUM_CNT-1:0]    wrap_vec, inc_vec, hit_vec;
  logic                  gen_q, gen_d, cnt_clr, tick;
  logic [NUM_AG-1:0]     amsk_q, amsk_d;
  logic [CODE_W-1:0]     type_q [NUM_CNT];
  logic [CODE_W-1:0]     type_d [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  // write decode
  always_comb begin
    wsel    = '0;
    cnt_wr  = '0;
    type_wr = '0;
    if (bus_we) begin
      case (bus_addr)
        OFS_ENSET: wsel.en_set  = 1'b1;
        OFS_ENCLR: wsel.en_clr  = 1'b1;
        OFS_IESET: wsel.ie_set  = 1'b1;
        OFS_IECLR: wsel.ie_clr  = 1'b1;
        OFS_OVF:   wsel.ovf_clr = 1'b1;
        OFS_CTRL:  wsel.ctrl    = 1'b1;
        OFS_AMSK0: wsel.amsk0   = 1'b1;
        OFS_AMSK1: wsel.amsk1   = 1'b1;
        default: ;
      endcase
      for (int n = 0; n < NUM_CNT; n++) begin
        if (bus_addr == OFS_CNT  + ADDR_W'(4*n)) cnt_wr[n]  = 1'b1;
        if (bus_addr == OFS_TYPE + ADDR_W'(4*n)) type_wr[n] = 1'b1;
      end
    end
  end

  assign cnt_clr = wsel.ctrl & bus_wdata[1];

  // next state of the control registers
  always_comb begin
    en_d = en_q;
    if (wsel.en_set) en_d = en_q | bus_wdata[NUM_CNT-1:0];
    if (wsel.en_clr) en_d = en_q & ~bus_wdata[NUM_CNT-1:0];
    ie_d = ie_q;
    if (wsel.ie_set) ie_d = ie_q | bus_wdata[NUM_CNT-1:0];
    if (wsel.ie_clr) ie_d = ie_q & ~bus_wdata[NUM_CNT-1:0];
    ovf_d = ovf_q;
    if (wsel.ovf_clr) ovf_d = ovf_q & ~bus_wdata[NUM_CNT-1:0];
    ovf_d = ovf_d | wrap_vec;
    gen_d = wsel.ctrl ? bus_wdata[0] : gen_q;
    amsk_d = amsk_q;
    if (wsel.amsk0) amsk_d[DATA_W-1:0]      = bus_wdata;
    if (wsel.amsk1) amsk_d[NUM_AG-1:DATA_W] = bus_wdata;
    for (int n = 0; n < NUM_CNT; n++)
      type_d[n] = type_wr[n] ? bus_wdata[CODE_W-1:0] : type_q[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ie_q   <= '0;
      ovf_q  <= '0;
      gen_q  <= 1'b0;
      amsk_q <= '0;
      for (int n = 0; n < NUM_CNT; n++) type_q[n] <= '0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      ovf_q  <= ovf_d;
      gen_q  <= gen_d;
      amsk_q <= amsk_d;
      for (int n = 0; n < NUM_CNT; n++) type_q[n] <= type_d[n];
    end
  end

  evc_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(gen_q), .clr(cnt_clr), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evc_select #(.NUM_EVT(NUM_EVT), .AG_W(AG_W)) u_sel (
      .code(type_q[g]), .tick(tick), .ev_pulse(ev_pulse),
      .ev_agent(ev_agent), .agent_mask(amsk_q), .hit(hit_vec[g])
    );
    assign inc_vec[g] = gen_q & en_q[g] & hit_vec[g];
    evc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(cnt_wr[g]), .wdata(bus_wdata[CNT_W-1:0]),
      .clr(cnt_clr), .inc(inc_vec[g]),
      .cnt(cnt_flat[g*CNT_W +: CNT_W]), .wrap(wrap_vec[g])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ENSET, OFS_ENCLR: bus_rdata[NUM_CNT-1:0] = en_q;
      OFS_IESET, OFS_IECLR: bus_rdata[NUM_CNT-1:0] = ie_q;
      OFS_OVF:              bus_rdata[NUM_CNT-1:0] = ovf_q;
      OFS_CTRL:             bus_rdata[0]           = gen_q;
      OFS_AMSK0:            bus_rdata = amsk_q[DATA_W-1:0];
      OFS_AMSK1:            bus_rdata = amsk_q[NUM_AG-1:DATA_W];
      default: ;
    endcase
    for (int n = 0; n < NUM_CNT; n++) begin
      if (bus_addr == OFS_CNT + ADDR_W'(4*n))
        bus_rdata[CNT_W-1:0] = cnt_flat[n*CNT_W +: CNT_W];
      if (bus_addr == OFS_TYPE + ADDR_W'(4*n))
        bus_rdata[CODE_W-1:0] = type_q[n];
    end
  end

  assign irq = |(ovf_q & ie_q);
endmodule

// File: rtl/evc_unit_chk.sv
module evc_unit_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_we,
  input logic [evc_pkg::ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       irq,
  input logic [NUM_CNT*CNT_W-1:0]   cnt_flat,
  input logic [NUM_CNT-1:0]         ovf_q,
  input logic [NUM_CNT-1:0]         inc_vec,
  input logic                       gen_q
);
  import evc_pkg::*;

  // R12: interrupt only with a pending overflow
  p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    // R2: a counter write loads the written value
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_CNT + ADDR_W'(4*g))
      |=> cnt_flat[g*CNT_W +: CNT_W] == $past(bus_wdata[CNT_W-1:0]));
    // R3: without writes a counter moves by at most one
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> (cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) ||
                   cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) + 1'b1));
    // R9: global enable off freezes every counter
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_q && !bus_we) |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
    // R10: counter-reset action zeroes the counter
    p_zeroed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_CTRL && bus_wdata[1])
      |=> cnt_flat[g*CNT_W +: CNT_W] == '0);
    // R11: a wrap raises the overflow flag
    p_wrap_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && inc_vec[g] && (&cnt_flat[g*CNT_W +: CNT_W])) |=> ovf_q[g]);
  end
endmodule

bind evc_unit evc_unit_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .cnt_flat(cnt_flat), .ovf_q(ovf_q),
  .inc_vec(inc_vec), .gen_q(gen_q)
);

// File: tb/evc_unit_test.sv
module evc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  ev_pulse = '0;
  logic [47:0] ev_agent = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "";
  bit    live = 0;

  evc_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
    .ev_agent(ev_agent), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit [31:0] m_cnt [4];
  bit [7:0]  m_type [4];
  bit [63:0] m_amsk;
  bit [3:0]  m_en, m_ie, m_ovf;
  bit        m_gen;
  int        m_pre;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_type[i] = 0; end
      m_amsk = 0; m_en = 0; m_ie = 0; m_ovf = 0; m_gen = 0; m_pre = 0;
    end else begin
      bit tk, hit, clr_all;
      bit [3:0] wraps;
      tk = m_gen && (m_pre == 63);
      clr_all = bus_we && bus_addr == 12'hE04 && bus_wdata[1];
      wraps = 0;
      for (int n = 0; n < 4; n++) begin
        int code;
        code = m_type[n];
        hit = 0;
        if (code == 0) hit = 1;
        else if (code == 1) hit = tk;
        else if (code >= 2 && code < 10)
          hit = ev_pulse[code-2] && !m_amsk[ev_agent[(code-2)*6 +: 6]];
        if (bus_we && bus_addr == 12'(4*n)) m_cnt[n] = bus_wdata;
        else if (clr_all) m_cnt[n] = 0;
        else if (m_gen && m_en[n] && hit) begin
          if (m_cnt[n] == 32'hFFFF_FFFF) wraps[n] = 1;
          m_cnt[n] = m_cnt[n] + 1;
        end
      end
      if (clr_all) m_pre = 0;
      else if (m_gen) m_pre = (m_pre + 1) % 64;
      if (bus_we) begin
        for (int n = 0; n < 4; n++)
          if (bus_addr == 12'h400 + 12'(4*n)) m_type[n] = bus_wdata[7:0];
        case (bus_addr)
          12'hA00: m_amsk[31:0]  = bus_wdata;
          12'hA04: m_amsk[63:32] = bus_wdata;
          12'hC00: m_en  = m_en | bus_wdata[3:0];
          12'hC20: m_en  = m_en & ~bus_wdata[3:0];
          12'hC40: m_ie  = m_ie | bus_wdata[3:0];
          12'hC60: m_ie  = m_ie & ~bus_wdata[3:0];
          12'hC80: m_ovf = m_ovf & ~bus_wdata[3:0];
          12'hE04: m_gen = bus_wdata[0];
          default: ;
        endcase
      end
      m_ovf = m_ovf | wraps;
    end
  end

  function automatic bit [31:0] mrd(input logic [11:0] a);
    for (int n = 0; n < 4; n++) begin
      if (a == 12'(4*n)) return m_cnt[n];
      if (a == 12'h400 + 12'(4*n)) return {24'h0, m_type[n]};
    end
    case (a)
      12'hA00: return m_amsk[31:0];
      12'hA04: return m_amsk[63:32];
      12'hC00, 12'hC20: return {28'h0, m_en};
      12'hC40, 12'hC60: return {28'h0, m_ie};
      12'hC80: return {28'h0, m_ovf};
      12'hE04: return {31'h0, m_gen};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (cur_tag != "") return cur_tag;
    if (a < 12'h010) return "R2";
    if (a >= 12'h400 && a < 12'h410) return "R3";
    case (a)
      12'hA00, 12'hA04: return "R6";
      12'hC00, 12'hC20: return "R7";
      12'hC40, 12'hC60: return "R8";
      12'hC80: return "R11";
      12'hE04: return "R9";
      default: return "R13";
    endcase
  endfunction

  task automatic compare();
    bit [31:0] exp_rd;
    bit        exp_irq;
    exp_rd  = mrd(bus_addr);
    exp_irq = |(m_ovf & m_ie);
    checks++;
    if (bus_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag_of(bus_addr), bus_addr, bus_rdata, exp_rd);
    end
    checks++;
    if (irq !== exp_irq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", (cur_tag != "") ? cur_tag : "R12", irq, exp_irq);
    end
  endtask

  task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input logic [7:0] p, input logic [47:0] ag);
    @(negedge clk);
    if (live) compare();
    bus_we = we; bus_addr = a; bus_wdata = d; ev_pulse = p; ev_agent = ag;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, a, d, 8'h00, 48'h0);
  endtask

  task automatic rd(input logic [11:0] a);
    step(0, a, 32'h0, 8'h00, 48'h0);
  endtask

  task automatic run(input int cyc);
    logic [11:0] rot [5] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'hC80};
    for (int i = 0; i < cyc; i++)
      step(0, rot[i % 5], 32'h0, 8'($urandom), {16'($urandom), 32'($urandom)});
  endtask

  task automatic read_all();
    logic [11:0] al [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h400, 12'h404,
                             12'h408, 12'h40C, 12'hA00, 12'hA04, 12'hC00, 12'hC20,
                             12'hC40, 12'hC60, 12'hC80, 12'hE04};
    for (int i = 0; i < 16; i++) rd(al[i]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    cur_tag = "R1"; read_all();

    cur_tag = "";
    wr(12'h400, 32'h0); wr(12'h404, 32'h1); wr(12'h408, 32'h2); wr(12'h40C, 32'h5);
    wr(12'hC00, 32'hF); wr(12'hC40, 32'h5); wr(12'hE04, 32'h1);
    run(300);
    cur_tag = "R3"; rd(12'h000);
    cur_tag = "R4"; rd(12'h004);
    cur_tag = "R5"; rd(12'h008); rd(12'h00C);

    cur_tag = "R6";
    wr(12'hA00, 32'hFFFF_00F0); wr(12'hA04, 32'hAAAA_AAAA);
    run(200); read_all();

    cur_tag = "R11";
    wr(12'h000, 32'hFFFF_FFF0);
    run(30);
    wr(12'hC80, 32'h2); rd(12'hC80);
    wr(12'hC80, 32'h1); rd(12'hC80);
    cur_tag = "R12";
    wr(12'h004, 32'hFFFF_FFFF);
    run(140); rd(12'hC80);
    wr(12'h000, 32'hFFFF_FFF8); run(20);

    cur_tag = "R8";
    wr(12'hC60, 32'h1); rd(12'hC40); rd(12'hC60); wr(12'hC40, 32'h0); rd(12'hC40);

    cur_tag = "R7";
    wr(12'hC20, 32'h3); run(50); wr(12'hC00, 32'h0); rd(12'hC00); rd(12'hC20);

    cur_tag = "R9";
    wr(12'hE04, 32'h0); run(80); read_all();

    cur_tag = "R10";
    wr(12'hE04, 32'h3); rd(12'hE04); read_all(); run(70);

    cur_tag = "R3";
    wr(12'h400, 32'h0001_FF00); rd(12'h400);
    cur_tag = "R5";
    wr(12'h40C, 32'h80); wr(12'hA00, 32'h0); wr(12'hA04, 32'h0);
    run(40); rd(12'h00C);

    cur_tag = "R13";
    wr(12'h100, 32'hFFFF_FFFF); rd(12'h100); rd(12'hFFC); rd(12'hA08); read_all();

    cur_tag = "R2";
    wr(12'hC00, 32'hF); wr(12'h408, 32'h0);
    wr(12'h000, 32'h8000_0000); wr(12'h008, 32'h0000_0010);
    run(60); read_all();

    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule